// File: doc/BRIEF.md
# Low-Power Mode Entry/Exit Controller

This block decides when a motor controller drops into a low-power condition and when it comes back out. The speed command can come from one of three sources: an analog level that has already been digitized, a digital speed pin, or a 9-bit command written through the register interface. Each source has its own idle condition, and that condition must hold without a break for a qualification time before the block enters low power. Another qualification time, which depends on the source and on the low-power variant, must pass before it exits. All times are counted in clock cycles and are set by parameters.

Two variants are supported. In standby the register interface and the register contents stay alive. In sleep the register interface is switched off and a one-cycle request is raised to clear the volatile register contents, so only the speed pin (in its digital or analog form) can wake the block. An inhibit bit prevents entry but never forces an exit. While low power is active, motor drive is withdrawn.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset, lp_active is 0, drive_en is 1, regif_en is 1 and reg_reset_req is 0.
- R2: With src_sel = 2'b00 (analog), entry happens once ana_level < ENTER_TH has held at T_ANA_SB consecutive clock edges (sleep_variant = 0) or at T_ANA_SL edges (sleep_variant = 1). lp_active rises after the last of those edges.
- R3: With src_sel = 2'b01 (pin), entry happens once spd_pin = 0 has held at T_PIN_SB (standby) or T_PIN_SL (sleep) consecutive edges.
- R4: With src_sel = 2'b10 or 2'b11 (register), standby is entered once spd_cmd = 0 has held at T_PIN_SB or T_PIN_SL consecutive edges. Standby is left once spd_cmd != 0 has held at T_XPIN edges.
- R5: In pin mode, spd_pin = 1 held at T_XPIN edges ends either variant. While asleep in register mode, spd_cmd has no effect and only spd_pin = 1 held at T_XPIN edges wakes the block.
- R6: In analog mode, standby ends once ana_level > EXIT_SB has held at T_XANA_SB edges, and sleep ends once ana_level > EXIT_SL (a higher level) has held at T_XANA_SL edges. A level between the two thresholds does not wake sleep.
- R7: A qualifying condition that drops for one edge restarts its count from zero. An edge at which src_sel or sleep_variant differs from its value at the previous edge (taken as 2'b00 and 0 after reset) does not count and also restarts the count.
- R8: While lp_inhibit = 1 the block does not enter low power. Raising lp_inhibit during low power does not cause an exit, and exit qualification still works.
- R9: drive_en is 0 exactly while lp_active is 1.
- R10: regif_en is 0 only while low power was entered with sleep_variant = 1. The variant is captured at entry, and later changes to sleep_variant do not alter it.
- R11: reg_reset_req is 1 for exactly the first cycle of a sleep entry, together with the rise of lp_active, and is never raised for a standby entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Command source: 00 analog, 01 pin, 10/11 register |
| ana_level | input | ANA_W | Digitized analog speed level |
| spd_pin | input | 1 | Digital speed pin level |
| spd_cmd | input | CMD_W | Register speed command |
| lp_inhibit | input | 1 | Blocks low-power entry |
| sleep_variant | input | 1 | 0 standby, 1 sleep |
| lp_active | output | 1 | Low-power status flag |
| drive_en | output | 1 | Motor drive enable |
| regif_en | output | 1 | Register interface enable |
| reg_reset_req | output | 1 | One-cycle volatile register reset request |

## Verification
A condition first seen at edge 1 reaches lp_active, drive_en and regif_en after edge N, where N is the qualification count. reg_reset_req appears in that same cycle and is gone one cycle later. The bench changes inputs only on falling edges. Each timed test first checks for no change after N-1 edges and then checks for the change after edge N. A cycle-level reference model, driven from the requirements, is compared with every output at each falling edge during both the directed and the random phases.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    SRC_ANALOG = 2'b00,
    SRC_PIN    = 2'b01,
    SRC_REG    = 2'b10,
    SRC_REG2   = 2'b11
  } lpm_src_e;

  function automatic int unsigned lpm_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/lpm_cond_sel.sv
module lpm_cond_sel
  import lpm_pkg::*;
#(
  parameter int unsigned ANA_W     = 9,
  parameter int unsigned CMD_W     = 9,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned ENTER_TH  = 17,
  parameter int unsigned EXIT_SB   = 21,
  parameter int unsigned EXIT_SL   = 380,
  parameter int unsigned T_ANA_SB  = 250,
  parameter int unsigned T_ANA_SL  = 260,
  parameter int unsigned T_PIN_SB  = 3000,
  parameter int unsigned T_PIN_SL  = 2900,
  parameter int unsigned T_XPIN    = 4,
  parameter int unsigned T_XANA_SB = 700,
  parameter int unsigned T_XANA_SL = 4
) (
  input  logic [1:0]       src_sel,
  input  logic [ANA_W-1:0] ana_level,
  input  logic             spd_pin,
  input  logic [CMD_W-1:0] spd_cmd,
  input  logic             lp_inhibit,
  input  logic             sleep_variant,
  input  logic             lp_q,
  input  logic             sleep_q,
  output logic             qual,
  output logic [CNT_W-1:0] limit
);
  localparam logic [ANA_W-1:0] TH_EN  = ANA_W'(ENTER_TH);
  localparam logic [ANA_W-1:0] TH_XSB = ANA_W'(EXIT_SB);
  localparam logic [ANA_W-1:0] TH_XSL = ANA_W'(EXIT_SL);
  localparam logic [CNT_W-1:0] L_ASB  = CNT_W'(T_ANA_SB);
  localparam logic [CNT_W-1:0] L_ASL  = CNT_W'(T_ANA_SL);
  localparam logic [CNT_W-1:0] L_PSB  = CNT_W'(T_PIN_SB);
  localparam logic [CNT_W-1:0] L_PSL  = CNT_W'(T_PIN_SL);
  localparam logic [CNT_W-1:0] L_XP   = CNT_W'(T_XPIN);
  localparam logic [CNT_W-1:0] L_XASB = CNT_W'(T_XANA_SB);
  localparam logic [CNT_W-1:0] L_XASL = CNT_W'(T_XANA_SL);

  lpm_src_e src;
  logic     cmd_zero;

  assign src      = lpm_src_e'(src_sel);
  assign cmd_zero = (spd_cmd == '0);

  always_comb begin
    qual  = 1'b0;
    limit = L_XP;
    if (!lp_q) begin
      unique case (src)
        SRC_ANALOG: begin
          qual  = (ana_level < TH_EN);
          limit = sleep_variant ? L_ASL : L_ASB;
        end
        SRC_PIN: begin
          qual  = !spd_pin;
          limit = sleep_variant ? L_PSL : L_PSB;
        end
        default: begin
          qual  = cmd_zero;
          limit = sleep_variant ? L_PSL : L_PSB;
        end
      endcase
      qual = qual && !lp_inhibit;
    end else if (sleep_q) begin
      if (src == SRC_ANALOG) begin
        qual  = (ana_level > TH_XSL);
        limit = L_XASL;
      end else begin
        qual  = spd_pin;
        limit = L_XP;
      end
    end else begin
      unique case (src)
        SRC_ANALOG: begin
          qual  = (ana_level > TH_XSB);
          limit = L_XASB;
        end
        SRC_PIN: begin
          qual  = spd_pin;
          limit = L_XP;
        end
        default: begin
          qual  = !cmd_zero;
          limit = L_XP;
        end
      endcase
    end
  end
endmodule

// File: rtl/lpm_qual_timer.sv
module lpm_qual_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign done = run && (cnt_q == (limit - 1'b1));

  always_comb begin
    if (!run || done) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lpm_state.sv
module lpm_state (
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  input  logic sleep_variant,
  output logic lp_q,
  output logic sleep_q,
  output logic req_q
);
  logic lp_d;
  logic sleep_d;
  logic req_d;
  logic enter;

  assign enter = done && !lp_q;

  always_comb begin
    lp_d    = lp_q;
    sleep_d = sleep_q;
    req_d   = 1'b0;
    if (done) lp_d = !lp_q;
    if (enter) begin
      sleep_d = sleep_variant;
      req_d   = sleep_variant;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_q    <= 1'b0;
      sleep_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      lp_q    <= lp_d;
      sleep_q <= sleep_d;
      req_q   <= req_d;
    end
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int unsigned ANA_W     = 9,
  parameter int unsigned CMD_W     = 9,
  parameter int unsigned ENTER_TH  = 17,
  parameter int unsigned EXIT_SB   = 21,
  parameter int unsigned EXIT_SL   = 380,
  parameter int unsigned T_ANA_SB  = 250,
  parameter int unsigned T_ANA_SL  = 260,
  parameter int unsigned T_PIN_SB  = 3000,
  parameter int unsigned T_PIN_SL  = 2900,
  parameter int unsigned T_XPIN    = 4,
  parameter int unsigned T_XANA_SB = 700,
  parameter int unsigned T_XANA_SL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       src_sel,
  input  logic [ANA_W-1:0] ana_level,
  input  logic             spd_pin,
  input  logic [CMD_W-1:0] spd_cmd,
  input  logic             lp_inhibit,
  input  logic             sleep_variant,
  output logic             lp_active,
  output logic             drive_en,
  output logic             regif_en,
  output logic             reg_reset_req
);
  localparam int unsigned T_MAX = lpm_max(lpm_max(lpm_max(T_ANA_SB, T_ANA_SL),
                                                  lpm_max(T_PIN_SB, T_PIN_SL)),
                                          lpm_max(T_XPIN, lpm_max(T_XANA_SB, T_XANA_SL)));
  localparam int unsigned CNT_W = $clog2(T_MAX + 1);

  logic [1:0]       src_q, src_d;
  logic             var_q, var_d;
  logic             cfg_chg;
  logic             qual, run, done;
  logic [CNT_W-1:0] limit;
  logic             lp_q, sleep_q, req_q;

  assign src_d   = src_sel;
  assign var_d   = sleep_variant;
  assign cfg_chg = (src_sel != src_q) || (sleep_variant != var_q);
  assign run     = qual && !cfg_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= 2'b00;
      var_q <= 1'b0;
    end else begin
      src_q <= src_d;
      var_q <= var_d;
    end
  end

  lpm_cond_sel #(
    .ANA_W(ANA_W), .CMD_W(CMD_W), .CNT_W(CNT_W),
    .ENTER_TH(ENTER_TH), .EXIT_SB(EXIT_SB), .EXIT_SL(EXIT_SL),
    .T_ANA_SB(T_ANA_SB), .T_ANA_SL(T_ANA_SL),
    .T_PIN_SB(T_PIN_SB), .T_PIN_SL(T_PIN_SL),
    .T_XPIN(T_XPIN), .T_XANA_SB(T_XANA_SB), .T_XANA_SL(T_XANA_SL)
  ) u_cond (
    .src_sel(src_sel), .ana_level(ana_level), .spd_pin(spd_pin),
    .spd_cmd(spd_cmd), .lp_inhibit(lp_inhibit), .sleep_variant(sleep_variant),
    .lp_q(lp_q), .sleep_q(sleep_q), .qual(qual), .limit(limit)
  );

  lpm_qual_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .limit(limit), .done(done)
  );

  lpm_state u_state (
    .clk(clk), .rst_n(rst_n), .done(done), .sleep_variant(sleep_variant),
    .lp_q(lp_q), .sleep_q(sleep_q), .req_q(req_q)
  );

  assign lp_active     = lp_q;
  assign drive_en      = !lp_q;
  assign regif_en      = !(lp_q && sleep_q);
  assign reg_reset_req = req_q;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic lp_inhibit,
  input logic lp_active,
  input logic drive_en,
  input logic regif_en,
  input logic reg_reset_req
);
  assert_drive_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lp_active |-> !drive_en);
  assert_drive_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !lp_active |-> drive_en);
  assert_regif_only_lp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !regif_en |-> lp_active);
  assert_req_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_reset_req |=> !reg_reset_req);
  assert_req_at_entry_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_reset_req |-> (lp_active && !regif_en));
  assert_inhibit_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!lp_active && lp_inhibit) |=> !lp_active);
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lp_inhibit(lp_inhibit), .lp_active(lp_active),
  .drive_en(drive_en), .regif_en(regif_en), .reg_reset_req(reg_reset_req)
);

// File: tb/lpm_ctrl_tb.sv
module lpm_ctrl_tb;
  localparam int ANA_W = 9, CMD_W = 9;
  localparam int ENTER_TH = 17, EXIT_SB = 21, EXIT_SL = 380;
  localparam int TA_SB = 50, TA_SL = 52, TP_SB = 300, TP_SL = 290;
  localparam int TXP = 4, TXA_SB = 70, TXA_SL = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] src_sel = 2'b00;
  logic [ANA_W-1:0] ana_level = '0;
  logic spd_pin = 1'b0;
  logic [CMD_W-1:0] spd_cmd = '0;
  logic lp_inhibit = 1'b0;
  logic sleep_variant = 1'b0;
  logic lp_active, drive_en, regif_en, reg_reset_req;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  lpm_ctrl #(
    .ANA_W(ANA_W), .CMD_W(CMD_W), .ENTER_TH(ENTER_TH), .EXIT_SB(EXIT_SB), .EXIT_SL(EXIT_SL),
    .T_ANA_SB(TA_SB), .T_ANA_SL(TA_SL), .T_PIN_SB(TP_SB), .T_PIN_SL(TP_SL),
    .T_XPIN(TXP), .T_XANA_SB(TXA_SB), .T_XANA_SL(TXA_SL)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .ana_level(ana_level),
    .spd_pin(spd_pin), .spd_cmd(spd_cmd), .lp_inhibit(lp_inhibit),
    .sleep_variant(sleep_variant), .lp_active(lp_active), .drive_en(drive_en),
    .regif_en(regif_en), .reg_reset_req(reg_reset_req)
  );

  // Reference model written from the requirements
  logic m_act, m_sl, m_req, m_var;
  logic [1:0] m_src;
  int m_cnt;

  function automatic bit ref_cond(input bit act, input bit sl);
    if (!act) begin
      if (lp_inhibit) return 0;
      if (src_sel == 2'b00) return ana_level < ENTER_TH;
      if (src_sel == 2'b01) return !spd_pin;
      return spd_cmd == 0;
    end
    if (sl) return (src_sel == 2'b00) ? (ana_level > EXIT_SL) : spd_pin;
    if (src_sel == 2'b00) return ana_level > EXIT_SB;
    if (src_sel == 2'b01) return spd_pin;
    return spd_cmd != 0;
  endfunction

  function automatic int ref_lim(input bit act, input bit sl);
    if (!act) begin
      if (src_sel == 2'b00) return sleep_variant ? TA_SL : TA_SB;
      return sleep_variant ? TP_SL : TP_SB;
    end
    if (src_sel != 2'b00) return TXP;
    return sl ? TXA_SL : TXA_SB;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_sl = 0; m_req = 0; m_cnt = 0; m_src = 2'b00; m_var = 0;
    end else begin
      bit chg, c;
      chg = (src_sel != m_src) || (sleep_variant != m_var);
      c = ref_cond(m_act, m_sl);
      m_req = 0;
      if (chg || !c) m_cnt = 0;
      else if (m_cnt + 1 >= ref_lim(m_act, m_sl)) begin
        m_cnt = 0;
        if (!m_act) begin
          m_sl = sleep_variant;
          m_req = sleep_variant;
        end
        m_act = !m_act;
      end else m_cnt = m_cnt + 1;
      m_src = src_sel;
      m_var = sleep_variant;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 model lp_active", lp_active, m_act);
      chk("R9 model drive_en", drive_en, !m_act);
      chk("R10 model regif_en", regif_en, !(m_act && m_sl));
      chk("R11 model reg_reset_req", reg_reset_req, m_req);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=200000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic setin(input logic [1:0] s, input logic v, input int a, input logic p,
                       input int c, input logic d);
    src_sel = s; sleep_variant = v; ana_level = ANA_W'(a);
    spd_pin = p; spd_cmd = CMD_W'(c); lp_inhibit = d;
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    setin(2'b00, 0, 100, 1, 5, 0);
    w(3);
    chk("R1 lp_active", lp_active, 1'b0);
    chk("R1 drive_en", drive_en, 1'b1);
    chk("R1 regif_en", regif_en, 1'b1);
    chk("R1 reg_reset_req", reg_reset_req, 1'b0);
    rst_n = 1'b1;
    w(2);
    chk("R1 after release", lp_active, 1'b0);

    // R3 pin standby entry
    setin(2'b01, 0, 100, 1, 5, 0); w(5);
    setin(2'b01, 0, 100, 0, 5, 0);
    w(TP_SB - 1); chk("R3 not yet", lp_active, 1'b0);
    w(1); chk("R3 standby entry", lp_active, 1'b1);
    chk("R9 drive off", drive_en, 1'b0);
    chk("R10 standby keeps regif", regif_en, 1'b1);
    chk("R11 no req standby", reg_reset_req, 1'b0);
    // R5 pin exit
    setin(2'b01, 0, 100, 1, 5, 0);
    w(TXP - 1); chk("R5 not yet", lp_active, 1'b1);
    w(1); chk("R5 pin exit", lp_active, 1'b0);
    chk("R9 drive on", drive_en, 1'b1);

    // R3 pin sleep entry
    setin(2'b01, 1, 100, 1, 5, 0); w(5);
    setin(2'b01, 1, 100, 0, 5, 0);
    w(TP_SL - 1); chk("R3 sleep not yet", lp_active, 1'b0);
    w(1); chk("R3 sleep entry", lp_active, 1'b1);
    chk("R11 req pulse", reg_reset_req, 1'b1);
    chk("R10 regif off", regif_en, 1'b0);
    w(1); chk("R11 req ends", reg_reset_req, 1'b0);
    // R5 register command ignored while asleep
    setin(2'b10, 1, 100, 0, 5, 0); w(50);
    chk("R5 cmd ignored asleep", lp_active, 1'b1);
    setin(2'b10, 0, 100, 0, 5, 0); w(50);
    chk("R10 variant latched", regif_en, 1'b0);
    chk("R5 still asleep", lp_active, 1'b1);
    setin(2'b10, 0, 100, 1, 5, 0); w(TXP);
    chk("R5 pin wakes sleep", lp_active, 1'b0);
    chk("R10 regif back", regif_en, 1'b1);

    // R4 register standby
    setin(2'b10, 0, 100, 1, 0, 0);
    w(TP_SB - 1); chk("R4 not yet", lp_active, 1'b0);
    w(1); chk("R4 reg entry", lp_active, 1'b1);
    setin(2'b10, 0, 100, 1, 7, 0);
    w(TXP - 1); chk("R4 exit not yet", lp_active, 1'b1);
    w(1); chk("R4 reg exit", lp_active, 1'b0);

    // R2/R6 analog standby
    setin(2'b00, 0, 100, 1, 7, 0); w(5);
    setin(2'b00, 0, 5, 1, 7, 0);
    w(TA_SB - 1); chk("R2 not yet", lp_active, 1'b0);
    w(1); chk("R2 analog standby entry", lp_active, 1'b1);
    setin(2'b00, 0, 19, 1, 7, 0); w(100);
    chk("R6 below exit level", lp_active, 1'b1);
    setin(2'b00, 0, 30, 1, 7, 0);
    w(TXA_SB - 1); chk("R6 not yet", lp_active, 1'b1);
    w(1); chk("R6 analog standby exit", lp_active, 1'b0);

    // R2/R6 analog sleep
    setin(2'b00, 1, 30, 1, 7, 0); w(5);
    setin(2'b00, 1, 5, 1, 7, 0);
    w(TA_SL - 1); chk("R2 sleep not yet", lp_active, 1'b0);
    w(1); chk("R2 analog sleep entry", lp_active, 1'b1);
    chk("R11 analog sleep req", reg_reset_req, 1'b1);
    setin(2'b00, 1, 200, 1, 7, 0); w(100);
    chk("R6 mid level no wake", lp_active, 1'b1);
    setin(2'b00, 1, 450, 1, 7, 0);
    w(TXA_SL - 1); chk("R6 sleep not yet", lp_active, 1'b1);
    w(1); chk("R6 analog sleep exit", lp_active, 1'b0);

    // R7 interrupted condition restarts
    setin(2'b01, 0, 450, 1, 7, 0); w(5);
    setin(2'b01, 0, 450, 0, 7, 0); w(TP_SB - 1);
    setin(2'b01, 0, 450, 1, 7, 0); w(1);
    setin(2'b01, 0, 450, 0, 7, 0);
    w(TP_SB - 1); chk("R7 restart not yet", lp_active, 1'b0);
    w(1); chk("R7 entry after restart", lp_active, 1'b1);
    setin(2'b01, 0, 450, 1, 7, 0); w(TXP);
    chk("R7 exit", lp_active, 1'b0);
    // R7 source change restarts
    setin(2'b01, 0, 450, 0, 7, 0); w(TP_SB - 1);
    setin(2'b10, 0, 450, 0, 0, 0);
    w(TP_SB); chk("R7 src change restart", lp_active, 1'b0);
    w(1); chk("R7 entry after src change", lp_active, 1'b1);
    setin(2'b10, 0, 450, 0, 7, 0); w(TXP);
    chk("R7 reg exit", lp_active, 1'b0);

    // R8 inhibit
    setin(2'b01, 0, 450, 1, 7, 1); w(5);
    setin(2'b01, 0, 450, 0, 7, 1); w(2 * TP_SB);
    chk("R8 inhibit blocks", lp_active, 1'b0);
    setin(2'b01, 0, 450, 0, 7, 0); w(TP_SB);
    chk("R8 entry once released", lp_active, 1'b1);
    setin(2'b01, 0, 450, 0, 7, 1); w(50);
    chk("R8 inhibit no wake", lp_active, 1'b1);
    setin(2'b01, 0, 450, 1, 7, 1); w(TXP);
    chk("R8 exit still works", lp_active, 1'b0);

    // Random phase against the model
    begin
      int seed_dummy;
      seed_dummy = $urandom(32'h1ee7);
    end
    for (int i = 0; i < 160; i++) begin
      int r, a, levels[4];
      levels[0] = 5; levels[1] = 19; levels[2] = 200; levels[3] = 450;
      r = int'($urandom_range(0, 99));
      a = levels[$urandom_range(0, 3)];
      setin((r < 80) ? src_sel : 2'($urandom_range(0, 3)),
            (r > 90) ? !sleep_variant : sleep_variant,
            a, 1'($urandom_range(0, 1)),
            ($urandom_range(0, 2) == 0) ? 0 : int'($urandom_range(1, 511)),
            ($urandom_range(0, 7) == 0));
      w(int'($urandom_range(1, 400)));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule